// File: doc/BRIEF.md
# Integer Execute Stage with Instruction Decode

This block is the execute stage of a simple 32-bit load/store integer pipeline. Each cycle it takes a 32-bit instruction word and the two register operands that were already read for it. It decodes the primary opcode and, for register-format words, the function code. It then picks the second ALU input: either the second register operand, or the 16-bit immediate extended to the data width. Whether that extension copies the sign or fills with zeros depends on the instruction. The result, the destination register index, a write-enable and an illegal-instruction flag are all registered, so they appear one clock after the inputs.

The register file, memory access, the program counter and arithmetic overflow traps are handled outside this block. Additions and subtractions wrap modulo 2^32. An instruction word the block does not recognise produces no register write and raises the illegal flag, so the surrounding pipeline can raise an exception.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next outputs are `result_o` = 0, `dest_o` = 0, `wr_en_o` = 0 and `illegal_o` = 0.
- R2: All outputs are registered. They change only at a rising clock edge and reflect the inputs present at that edge.
- R3: A register-format word (bits 31:26 = 0) with function bits 5:0 = 0x21 yields `opa_i + opb_i` modulo 2^32, with the destination taken from bits 15:11 and no overflow trap.
- R4: A register-format word with function 0x23 yields `opa_i - opb_i` modulo 2^32, with the destination taken from bits 15:11.
- R5: Register-format function 0x24 yields bitwise AND, 0x25 yields bitwise OR, and 0x27 yields bitwise NOR of the two operands, each with the destination taken from bits 15:11.
- R6: Opcode 8 yields `opa_i` plus the immediate in bits 15:0, sign-extended by copying bit 15 into bits 31:16. The destination is taken from bits 20:16.
- R7: Opcode 12 yields `opa_i` AND the zero-extended immediate. Opcode 13 yields `opa_i` OR the zero-extended immediate. Both take the destination from bits 20:16.
- R8: Any other opcode, or opcode 0 with any other function code, gives `illegal_o` = 1, `wr_en_o` = 0, `result_o` = 0 and `dest_o` = 0.
- R9: A legal instruction whose destination index is 0 still computes `result_o` and reports `dest_o` = 0, but `wr_en_o` stays 0 and `illegal_o` stays 0.
- R10: The shift-amount field (bits 10:6) has no effect on any result. `opb_i` has no effect on immediate-format results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word to execute |
| opa_i | input | DATA_W | First source register value |
| opb_i | input | DATA_W | Second source register value |
| result_o | output | DATA_W | Registered ALU result |
| dest_o | output | 5 | Registered destination register index |
| wr_en_o | output | 1 | Registered register-file write-enable |
| illegal_o | output | 1 | Registered illegal-instruction flag |

## Verification
Operand pairs are chosen so that each operation produces a value no other covered operation would give. The AND, OR and NOR cases share one pair of partly overlapping bit patterns, and this exposes any swapped function code. The immediate cases use values with bit 15 set and clear, so an immediate that is sign-extended where it should be zero-extended, or the reverse, shows up in the upper half. The immediate cases also take the destination from a different field than the register cases. Wrap-around sums, destination-zero words, a non-zero shift-amount field, a garbage second operand on immediate words, and unlisted opcodes and function codes separate the write-enable gating from the decode, and show that the ignored fields are truly ignored.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

  localparam int INSTR_W   = 32;
  localparam int OPC_W     = 6;
  localparam int FN_W      = 6;
  localparam int REG_IDX_W = 5;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'd8;
  localparam logic [OPC_W-1:0] OPC_ANDI = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'd13;

  localparam logic [FN_W-1:0] FN_ADD = 6'h21;
  localparam logic [FN_W-1:0] FN_SUB = 6'h23;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_NOR = 6'h27;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_NOR
  } alu_fn_e;

  typedef struct packed {
    alu_fn_e              fn;
    logic                 use_imm;
    logic                 sext;
    logic                 legal;
    logic [REG_IDX_W-1:0] dest;
  } dec_s;

endpackage

// File: rtl/exec_decoder.sv
module exec_decoder
  import int_exec_pkg::*;
(
  input  logic [OPC_W-1:0]     opc_i,
  input  logic [FN_W-1:0]      fn_i,
  input  logic [REG_IDX_W-1:0] rt_i,
  input  logic [REG_IDX_W-1:0] rd_i,
  output dec_s                 dec_o
);

  always_comb begin
    dec_o = '0;
    unique case (opc_i)
      OPC_REG: begin
        dec_o.dest  = rd_i;
        dec_o.legal = 1'b1;
        unique case (fn_i)
          FN_ADD:  dec_o.fn = ALU_ADD;
          FN_SUB:  dec_o.fn = ALU_SUB;
          FN_AND:  dec_o.fn = ALU_AND;
          FN_OR:   dec_o.fn = ALU_OR;
          FN_NOR:  dec_o.fn = ALU_NOR;
          default: dec_o.legal = 1'b0;
        endcase
      end
      OPC_ADDI: begin
        dec_o.fn      = ALU_ADD;
        dec_o.use_imm = 1'b1;
        dec_o.sext    = 1'b1;
        dec_o.dest    = rt_i;
        dec_o.legal   = 1'b1;
      end
      OPC_ANDI: begin
        dec_o.fn      = ALU_AND;
        dec_o.use_imm = 1'b1;
        dec_o.dest    = rt_i;
        dec_o.legal   = 1'b1;
      end
      OPC_ORI: begin
        dec_o.fn      = ALU_OR;
        dec_o.use_imm = 1'b1;
        dec_o.dest    = rt_i;
        dec_o.legal   = 1'b1;
      end
      default: dec_o.legal = 1'b0;
    endcase
    if (!dec_o.legal) begin
      dec_o.dest = '0;
    end
  end

endmodule

// File: rtl/exec_operand_sel.sv
module exec_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] reg_b_i,
  input  logic              use_imm_i,
  input  logic              sext_i,
  output logic [DATA_W-1:0] opnd_b_o
);

  localparam int FILL_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  generate
    if (FILL_W > 0) begin : g_widen
      logic fill_bit;
      assign fill_bit = sext_i & imm_i[IMM_W-1];
      assign imm_ext  = {{FILL_W{fill_bit}}, imm_i};
    end else begin : g_same
      logic unused_sext;
      assign unused_sext = sext_i;
      assign imm_ext     = imm_i[DATA_W-1:0];
    end
  endgenerate

  assign opnd_b_o = use_imm_i ? imm_ext : reg_b_i;

endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_fn_e           fn_i,
  output logic [DATA_W-1:0] y_o
);

  always_comb begin
    unique case (fn_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_NOR: y_o = ~(a_i | b_i);
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [DATA_W-1:0]    opa_i,
  input  logic [DATA_W-1:0]    opb_i,
  output logic [DATA_W-1:0]    result_o,
  output logic [REG_IDX_W-1:0] dest_o,
  output logic                 wr_en_o,
  output logic                 illegal_o
);

  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int RS_LSB  = OPC_LSB - REG_IDX_W;
  localparam int RT_LSB  = RS_LSB - REG_IDX_W;
  localparam int RD_LSB  = RT_LSB - REG_IDX_W;

  dec_s              dec;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_y;
  logic              unused_fields;

  // Source index and shift amount are not needed: operands arrive already read.
  assign unused_fields = ^{instr_i[RS_LSB +: REG_IDX_W], instr_i[RD_LSB-1:FN_W]};

  exec_decoder u_dec (
    .opc_i (instr_i[OPC_LSB +: OPC_W]),
    .fn_i  (instr_i[FN_W-1:0]),
    .rt_i  (instr_i[RT_LSB +: REG_IDX_W]),
    .rd_i  (instr_i[RD_LSB +: REG_IDX_W]),
    .dec_o (dec)
  );

  exec_operand_sel #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_opsel (
    .imm_i     (instr_i[IMM_W-1:0]),
    .reg_b_i   (opb_i),
    .use_imm_i (dec.use_imm),
    .sext_i    (dec.sext),
    .opnd_b_o  (opnd_b)
  );

  exec_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .a_i  (opa_i),
    .b_i  (opnd_b),
    .fn_i (dec.fn),
    .y_o  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      dest_o    <= '0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      result_o  <= dec.legal ? alu_y : '0;
      dest_o    <= dec.dest;
      wr_en_o   <= dec.legal && (dec.dest != '0);
      illegal_o <= !dec.legal;
    end
  end

endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [INSTR_W-1:0]   instr_i,
  input logic [DATA_W-1:0]    opa_i,
  input logic [DATA_W-1:0]    opb_i,
  input logic [DATA_W-1:0]    result_o,
  input logic [REG_IDX_W-1:0] dest_o,
  input logic                 wr_en_o,
  input logic                 illegal_o
);

  localparam int FILL_W = DATA_W - IMM_W;

  logic unused_chk;
  assign unused_chk = ^instr_i;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (result_o == '0 && dest_o == '0 && !wr_en_o && !illegal_o));

  // R3
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_i[31:26]) == OPC_REG && $past(instr_i[5:0]) == FN_ADD)
    |-> (result_o == $past(opa_i) + $past(opb_i) && dest_o == $past(instr_i[15:11])
         && !illegal_o));

  // R6
  addi_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_i[31:26]) == OPC_ADDI)
    |-> (result_o == $past(opa_i) +
           {{FILL_W{$past(instr_i[IMM_W-1])}}, $past(instr_i[IMM_W-1:0])}
         && dest_o == $past(instr_i[20:16])));

  // R8
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!wr_en_o && dest_o == '0 && result_o == '0));

  // R9
  zero_dest_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (dest_o != '0 && !illegal_o));

endmodule

bind int_exec_unit int_exec_unit_chk #(
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .instr_i   (instr_i),
  .opa_i     (opa_i),
  .opb_i     (opb_i),
  .result_o  (result_o),
  .dest_o    (dest_o),
  .wr_en_o   (wr_en_o),
  .illegal_o (illegal_o)
);

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'd0;
  logic [31:0] opa = 32'd0;
  logic [31:0] opb = 32'd0;
  logic [31:0] result;
  logic [4:0]  dest;
  logic        wr_en;
  logic        illegal;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  int_exec_unit uut (
    .clk       (clk),
    .rst       (rst),
    .instr_i   (instr),
    .opa_i     (opa),
    .opb_i     (opb),
    .result_o  (result),
    .dest_o    (dest),
    .wr_en_o   (wr_en),
    .illegal_o (illegal)
  );

  function automatic logic [31:0] rw(input logic [4:0] rs, rt, rd, sh, input logic [5:0] fn);
    return {6'd0, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] iw(input logic [5:0] op, input logic [4:0] rs, rt,
                                     input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic drive(input logic [31:0] ins, a, b);
    @(negedge clk);
    instr = ins;
    opa   = a;
    opb   = b;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [31:0] er, input logic [4:0] ed,
                            input logic ew, input logic ei);
    total++;
    if (result !== er || dest !== ed || wr_en !== ew || illegal !== ei) begin
      fails++;
      $display("FAIL %s: got res=%h dest=%0d we=%b ill=%b, expected res=%h dest=%0d we=%b ill=%b",
               tag, result, dest, wr_en, illegal, er, ed, ew, ei);
    end
  endtask

  task automatic t_reset;
    drive(rw(5'd1, 5'd2, 5'd3, 5'd0, 6'h21), 32'd11, 32'd22);
    expect_out("R1 reset holds outputs clear", 32'd0, 5'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_latency;
    drive(rw(5'd1, 5'd2, 5'd4, 5'd0, 6'h21), 32'd100, 32'd23);
    expect_out("R2 first result after edge", 32'd123, 5'd4, 1'b1, 1'b0);
    @(negedge clk);
    instr = rw(5'd1, 5'd2, 5'd6, 5'd0, 6'h23);
    opa = 32'd50;
    opb = 32'd8;
    #1;
    expect_out("R2 no change before edge", 32'd123, 5'd4, 1'b1, 1'b0);
    @(posedge clk);
    #1;
    expect_out("R2 new result after edge", 32'd42, 5'd6, 1'b1, 1'b0);
  endtask

  task automatic t_add;
    drive(rw(5'd3, 5'd4, 5'd7, 5'd0, 6'h21), 32'h7fff_ffff, 32'd1);
    expect_out("R3 add signed overflow wraps", 32'h8000_0000, 5'd7, 1'b1, 1'b0);
    drive(rw(5'd3, 5'd4, 5'd31, 5'd0, 6'h21), 32'hffff_ffff, 32'd2);
    expect_out("R3 add carry out dropped", 32'd1, 5'd31, 1'b1, 1'b0);
  endtask

  task automatic t_sub;
    drive(rw(5'd3, 5'd4, 5'd9, 5'd0, 6'h23), 32'd5, 32'd7);
    expect_out("R4 subtract borrow wraps", 32'hffff_fffe, 5'd9, 1'b1, 1'b0);
  endtask

  task automatic t_logic;
    drive(rw(5'd1, 5'd2, 5'd10, 5'd0, 6'h24), 32'hf0f0_1234, 32'h0ff0_ff00);
    expect_out("R5 AND", 32'h00f0_1200, 5'd10, 1'b1, 1'b0);
    drive(rw(5'd1, 5'd2, 5'd11, 5'd0, 6'h25), 32'hf0f0_1234, 32'h0ff0_ff00);
    expect_out("R5 OR", 32'hfff0_ff34, 5'd11, 1'b1, 1'b0);
    drive(rw(5'd1, 5'd2, 5'd12, 5'd0, 6'h27), 32'hf0f0_1234, 32'h0ff0_ff00);
    expect_out("R5 NOR", 32'h000f_00cb, 5'd12, 1'b1, 1'b0);
  endtask

  task automatic t_addi;
    // opb carries garbage: R10 requires it to be ignored here
    drive(iw(6'd8, 5'd1, 5'd13, 16'hffff), 32'd10, 32'hdead_beef);
    expect_out("R6 addi negative imm, R10 opb ignored", 32'd9, 5'd13, 1'b1, 1'b0);
    drive(iw(6'd8, 5'd1, 5'd14, 16'h7fff), 32'd1, 32'h1234_5678);
    expect_out("R6 addi positive imm", 32'h0000_8000, 5'd14, 1'b1, 1'b0);
  endtask

  task automatic t_logic_imm;
    drive(iw(6'd12, 5'd1, 5'd15, 16'h8001), 32'hffff_ffff, 32'h5555_5555);
    expect_out("R7 andi zero extension", 32'h0000_8001, 5'd15, 1'b1, 1'b0);
    drive(iw(6'd13, 5'd1, 5'd16, 16'h8000), 32'h1234_0000, 32'hffff_ffff);
    expect_out("R7 ori zero extension", 32'h1234_8000, 5'd16, 1'b1, 1'b0);
  endtask

  task automatic t_illegal;
    drive(rw(5'd1, 5'd2, 5'd3, 5'd0, 6'h20), 32'd1, 32'd2);
    expect_out("R8 unlisted func 0x20", 32'd0, 5'd0, 1'b0, 1'b1);
    drive(rw(5'd1, 5'd2, 5'd3, 5'd0, 6'h26), 32'd1, 32'd2);
    expect_out("R8 unlisted func 0x26", 32'd0, 5'd0, 1'b0, 1'b1);
    drive(iw(6'h23, 5'd1, 5'd5, 16'h0004), 32'd1, 32'd2);
    expect_out("R8 unlisted opcode 0x23", 32'd0, 5'd0, 1'b0, 1'b1);
  endtask

  task automatic t_zero_dest;
    drive(rw(5'd1, 5'd2, 5'd0, 5'd0, 6'h21), 32'd3, 32'd4);
    expect_out("R9 register dest 0", 32'd7, 5'd0, 1'b0, 1'b0);
    drive(iw(6'd13, 5'd1, 5'd0, 16'h00f0), 32'h0000_000f, 32'd0);
    expect_out("R9 immediate dest 0", 32'h0000_00ff, 5'd0, 1'b0, 1'b0);
  endtask

  task automatic t_shamt;
    drive(rw(5'd1, 5'd2, 5'd17, 5'd31, 6'h21), 32'd40, 32'd2);
    expect_out("R10 shamt ignored on add", 32'd42, 5'd17, 1'b1, 1'b0);
    drive(rw(5'd1, 5'd2, 5'd18, 5'd5, 6'h27), 32'd0, 32'd0);
    expect_out("R10 shamt ignored on NOR", 32'hffff_ffff, 5'd18, 1'b1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_add();
    t_sub();
    t_logic();
    t_addi();
    t_logic_imm();
    t_illegal();
    t_zero_dest();
    t_shamt();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #200_000;
    total++;
    fails++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule